// File: doc/BRIEF.md
# Per-Processor Device Interrupt Router

The router takes up to 64 device interrupt request lines and steers them to four processors. A single raw request register holds the current state of every device line, and all processors share it. Each processor has its own 64-bit enable mask. A per-processor effective vector is kept equal to mask AND raw at all times. Each processor's level interrupt output is high while any bit of its effective vector is set.

Every change that matters to a processor produces a post or clear event on a one-cycle strobe. The strobe carries the processor index and the 6-bit interrupt number. Events come from three sources: mask writes, device raises and device lowers. A small pending store holds them, and the event queue sends them out one per cycle. The event queue is a two-state machine. `EQ_IDLE` moves to `EQ_DRAIN` when the pending store is non-empty. `EQ_DRAIN` sends the lowest pending event each cycle and stays there while events remain, including events that arrive in the same cycle. It returns to `EQ_IDLE` when the updated store is empty.

Software reaches the masks, the effective vectors and the raw register through a 64-bit register port. The port answers every request one cycle later and sets a sticky error flag for illegal accesses.

Top module: `irq_router`

## Requirements
- R1: After reset, every mask, every effective vector and the raw register read as zero, all `cpu_irq` bits are 0 and `reg_err` is 0.
- R2: For every processor, the effective vector equals its mask AND the raw register after every clock, whichever of the two changed.
- R3: A mask write posts interrupt b to that processor for each bit b that changed and is set in the new effective vector.
- R4: A mask write issues a clear for each changed bit that was set in the old effective vector and is clear in the new one. A changed bit whose raw bit is 0 produces no event.
- R5: Raising device line n sets raw bit n and posts n to every processor whose mask has bit n set.
- R6: Lowering line n while raw bit n is 1 clears raw bit n and sends a clear for n to every processor whose effective vector had bit n set.
- R7: Lowering line n while raw bit n is already 0 changes no register and produces no event.
- R8: Register index = (`reg_addr` − BASE) >> 6. Index c (0..3) is the mask of processor c, index 4+c is the effective vector of processor c, and index 8 is raw. Read data appears on `reg_rdata` with `reg_rsp` one cycle after `reg_req`.
- R9: The following accesses are illegal: a size other than `reg_size`=3 (8 bytes), any index above 8 (including addresses below BASE), and any write to index 4..8. An illegal access sets `reg_err`, which stays set until reset, returns zero read data and changes no register.
- R10: `cpu_irq[c]` is the OR of all bits of processor c's effective vector.
- R11: Events leave one per cycle on `evt_valid`. `evt_post`=1 means post and 0 means clear. The lowest processor index goes first, and within a processor the lowest interrupt number goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request, one cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 32 | Physical byte address |
| reg_size | input | 2 | log2 of access bytes; only 3 is legal |
| reg_wdata | input | 64 | Write data |
| reg_rsp | output | 1 | Response strobe, one cycle after request |
| reg_rdata | output | 64 | Read data, zero for writes and illegal reads |
| reg_err | output | 1 | Sticky illegal-access flag |
| dev_valid | input | 1 | Device line event this cycle |
| dev_raise | input | 1 | 1 = raise, 0 = lower |
| dev_line | input | 6 | Device line number |
| cpu_irq | output | 4 | Level interrupt per processor |
| evt_valid | output | 1 | Event strobe |
| evt_post | output | 1 | 1 = post, 0 = clear |
| evt_cpu | output | 2 | Target processor |
| evt_num | output | 6 | Interrupt number |

## Verification
Mask writes are tried three ways: bits entering the effective vector, bits leaving it, and bits changing while their raw bit is 0. Together these separate posting on a changed bit from posting on any set bit, and show that a mask change alone never fires an event. Device raises are driven against a mix of masks. Some hit one processor, some several, and some hit the extreme line numbers 0 and 63, which exposes any error in the processor-then-number ordering of the event stream. A lower is repeated so that a real clear can be told apart from a spurious one. Illegal writes, bad sizes and out-of-range addresses are each followed by reads that show the registers kept their values.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    typedef enum logic [0:0] {
        EQ_IDLE  = 1'b0,
        EQ_DRAIN = 1'b1
    } evq_state_e;

    localparam logic [1:0] SIZE_8B   = 2'd3;
    localparam int         IDX_SHIFT = 6;
endpackage

// File: rtl/irq_core.sv
module irq_core
    import irq_router_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int NLINES = 64,
    localparam int LW    = $clog2(NLINES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCPU-1:0]               mask_we,
    input  logic [NLINES-1:0]             wdata,
    input  logic                          dev_valid,
    input  logic                          dev_raise,
    input  logic [LW-1:0]                 dev_line,
    output logic [NCPU-1:0][NLINES-1:0]   mask_q,
    output logic [NCPU-1:0][NLINES-1:0]   eff_q,
    output logic [NLINES-1:0]             raw_q,
    output logic [NCPU-1:0][NLINES-1:0]   new_post,
    output logic [NCPU-1:0][NLINES-1:0]   new_clr
);
    logic [NLINES-1:0] line_vec;
    logic [NLINES-1:0] raw_n;

    assign line_vec = NLINES'(1) << dev_line;

    always_comb begin
        raw_n = raw_q;
        if (dev_valid) begin
            if (dev_raise) raw_n = raw_q | line_vec;
            else           raw_n = raw_q & ~line_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_n;
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NLINES-1:0] mask_n, chg, eff_n, raise_hit, lower_hit;

        always_comb begin
            mask_n    = mask_we[c] ? wdata : mask_q[c];
            chg       = mask_we[c] ? (mask_q[c] ^ wdata) : '0;
            eff_n     = mask_n & raw_n;
            raise_hit = (dev_valid && dev_raise)  ? (line_vec & mask_q[c]) : '0;
            lower_hit = (dev_valid && !dev_raise) ? (line_vec & eff_q[c])  : '0;
            new_post[c] = (chg & eff_n) | raise_hit;
            new_clr[c]  = (chg & eff_q[c] & ~eff_n) | lower_hit;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[c] <= '0;
                eff_q[c]  <= '0;
            end else begin
                mask_q[c] <= mask_n;
                eff_q[c]  <= eff_n;
            end
        end

        // R2: effective register tracks mask AND raw
        p_eff_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
            eff_q[c] == (mask_q[c] & raw_q));
    end

    // R5: a raise leaves the raw bit set
    p_raise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && dev_raise) |=> raw_q[$past(dev_line)]);

    // R7: a spurious lower leaves raw untouched
    p_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && !dev_raise && !raw_q[dev_line]) |=> $stable(raw_q));
endmodule

// File: rtl/irq_regport.sv
module irq_regport
    import irq_router_pkg::*;
#(
    parameter int              NCPU   = 4,
    parameter int              NLINES = 64,
    parameter int              ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE = 32'h0000_2000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic                        wr,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [1:0]                  size,
    input  logic [NLINES-1:0]           wdata,
    input  logic [NCPU-1:0][NLINES-1:0] mask_q,
    input  logic [NCPU-1:0][NLINES-1:0] eff_q,
    input  logic [NLINES-1:0]           raw_q,
    output logic [NCPU-1:0]             mask_we,
    output logic                        rsp,
    output logic [NLINES-1:0]           rdata,
    output logic                        err
);
    localparam logic [ADDR_W-1:0] IDX_RAW = ADDR_W'(2 * NCPU);

    logic [ADDR_W-1:0] idx;
    logic [NLINES-1:0] rd;
    logic              size_ok, is_mask, is_ro, legal;

    assign idx = (addr - BASE) >> IDX_SHIFT;

    always_comb begin
        rd      = '0;
        is_mask = 1'b0;
        is_ro   = (idx == IDX_RAW);
        if (idx == IDX_RAW) rd = raw_q;
        for (int c = 0; c < NCPU; c++) begin
            if (idx == ADDR_W'(c)) begin
                rd      = mask_q[c];
                is_mask = 1'b1;
            end
            if (idx == ADDR_W'(NCPU + c)) begin
                rd    = eff_q[c];
                is_ro = 1'b1;
            end
        end
        size_ok = (size == SIZE_8B);
        legal   = size_ok && (is_mask || (!wr && is_ro));
        for (int c = 0; c < NCPU; c++)
            mask_we[c] = req && wr && legal && (idx == ADDR_W'(c));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp   <= 1'b0;
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rsp   <= req;
            rdata <= (req && !wr && legal) ? rd : '0;
            if (req && !legal) err <= 1'b1;
        end
    end

    // R9: a bad size answers with zero and the error flag
    p_bad_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && size != SIZE_8B) |=> (rsp && rdata == '0 && err));

    // R9: the error flag is sticky
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err) |-> err);
endmodule

// File: rtl/irq_evq.sv
module irq_evq
    import irq_router_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int NLINES = 64,
    localparam int LW    = $clog2(NLINES),
    localparam int CW    = $clog2(NCPU)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCPU-1:0][NLINES-1:0] new_post,
    input  logic [NCPU-1:0][NLINES-1:0] new_clr,
    output logic                        evt_valid,
    output logic                        evt_post,
    output logic [CW-1:0]               evt_cpu,
    output logic [LW-1:0]               evt_num
);
    evq_state_e                  state_q, state_n;
    logic [NCPU-1:0][NLINES-1:0] pend_q, pend_n, kind_q, kind_n;
    logic [CW-1:0]               sel_c;
    logic [LW-1:0]               sel_b;
    logic                        found, emit;

    // lowest processor first, then lowest bit
    always_comb begin
        found = 1'b0;
        sel_c = '0;
        sel_b = '0;
        for (int c = 0; c < NCPU; c++)
            for (int b = 0; b < NLINES; b++)
                if (!found && pend_q[c][b]) begin
                    found = 1'b1;
                    sel_c = CW'(c);
                    sel_b = LW'(b);
                end
    end

    assign emit = (state_q == EQ_DRAIN);

    always_comb begin
        pend_n = pend_q;
        kind_n = kind_q;
        if (emit) pend_n[sel_c][sel_b] = 1'b0;
        for (int c = 0; c < NCPU; c++) begin
            pend_n[c] = pend_n[c] | new_post[c] | new_clr[c];
            kind_n[c] = (kind_n[c] & ~(new_post[c] | new_clr[c]))
                      | (new_post[c] & ~new_clr[c]);
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            EQ_IDLE:  state_n = (pend_q != '0) ? EQ_DRAIN : EQ_IDLE;
            EQ_DRAIN: state_n = (pend_n != '0) ? EQ_DRAIN : EQ_IDLE;
            default:  state_n = EQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EQ_IDLE;
            pend_q  <= '0;
            kind_q  <= '0;
        end else begin
            state_q <= state_n;
            pend_q  <= pend_n;
            kind_q  <= kind_n;
        end
    end

    always_comb begin
        evt_valid = emit && found;
        evt_post  = kind_q[sel_c][sel_b];
        evt_cpu   = sel_c;
        evt_num   = sel_b;
    end

    // R11: draining only happens with work pending
    p_drain_work_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EQ_DRAIN) |-> (pend_q != '0));
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int                NCPU   = 4,
    parameter int                NLINES = 64,
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = 32'h0000_2000,
    localparam int               LW     = $clog2(NLINES),
    localparam int               CW     = $clog2(NCPU)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [NLINES-1:0] reg_wdata,
    output logic              reg_rsp,
    output logic [NLINES-1:0] reg_rdata,
    output logic              reg_err,
    input  logic              dev_valid,
    input  logic              dev_raise,
    input  logic [LW-1:0]     dev_line,
    output logic [NCPU-1:0]   cpu_irq,
    output logic              evt_valid,
    output logic              evt_post,
    output logic [CW-1:0]     evt_cpu,
    output logic [LW-1:0]     evt_num
);
    logic [NCPU-1:0]             mask_we;
    logic [NCPU-1:0][NLINES-1:0] mask_q, eff_q, new_post, new_clr;
    logic [NLINES-1:0]           raw_q;

    irq_regport #(.NCPU(NCPU), .NLINES(NLINES), .ADDR_W(ADDR_W), .BASE(BASE)) u_port (
        .clk(clk), .rst_n(rst_n), .req(reg_req), .wr(reg_wr), .addr(reg_addr),
        .size(reg_size), .wdata(reg_wdata), .mask_q(mask_q), .eff_q(eff_q),
        .raw_q(raw_q), .mask_we(mask_we), .rsp(reg_rsp), .rdata(reg_rdata),
        .err(reg_err)
    );

    irq_core #(.NCPU(NCPU), .NLINES(NLINES)) u_core (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .wdata(reg_wdata),
        .dev_valid(dev_valid), .dev_raise(dev_raise), .dev_line(dev_line),
        .mask_q(mask_q), .eff_q(eff_q), .raw_q(raw_q),
        .new_post(new_post), .new_clr(new_clr)
    );

    irq_evq #(.NCPU(NCPU), .NLINES(NLINES)) u_evq (
        .clk(clk), .rst_n(rst_n), .new_post(new_post), .new_clr(new_clr),
        .evt_valid(evt_valid), .evt_post(evt_post), .evt_cpu(evt_cpu),
        .evt_num(evt_num)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_irq
        assign cpu_irq[c] = |eff_q[c];
    end
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
    localparam logic [31:0] BASE = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_addr = '0;
    logic [1:0]  reg_size = 2'd3;
    logic [63:0] reg_wdata = '0;
    logic        reg_rsp, reg_err;
    logic [63:0] reg_rdata;
    logic        dev_valid = 1'b0, dev_raise = 1'b0;
    logic [5:0]  dev_line = '0;
    logic [3:0]  cpu_irq;
    logic        evt_valid, evt_post;
    logic [1:0]  evt_cpu;
    logic [5:0]  evt_num;

    int tests = 0, fails = 0;
    logic [63:0] m_mask [4];
    logic [63:0] m_raw = '0;
    logic        m_err = 1'b0;
    logic        mon_on = 1'b0;
    int          exp_q[$], got_q[$];

    always #10 clk = ~clk;

    irq_router uut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R10/R2: compare level outputs with the model every clock
    always @(negedge clk) begin
        if (mon_on) begin
            logic [3:0] e;
            for (int c = 0; c < 4; c++) e[c] = |(m_mask[c] & m_raw);
            chk("R10 cpu_irq", 64'(cpu_irq), 64'(e));
            if (evt_valid) got_q.push_back(int'(evt_post) * 1000 + int'(evt_cpu) * 100 + int'(evt_num));
        end
    end

    function automatic int ev(input int post, input int c, input int b);
        return post * 1000 + c * 100 + b;
    endfunction

    task automatic access(input logic wr, input int idx, input logic [1:0] sz,
                          input logic [63:0] d, input logic [31:0] addr_ovr,
                          input logic use_ovr, output logic [63:0] rd);
        logic illegal;
        illegal = (sz != 2'd3) || use_ovr || idx > 8 || (wr && idx >= 4);
        @(negedge clk);
        reg_req = 1'b1; reg_wr = wr; reg_size = sz; reg_wdata = d;
        reg_addr = use_ovr ? addr_ovr : BASE + 32'(idx) * 64;
        @(posedge clk);
        if (illegal) m_err = 1'b1;
        else if (wr) begin
            for (int b = 0; b < 64; b++) begin
                logic ch, oe, ne;
                ch = m_mask[idx][b] ^ d[b];
                oe = m_mask[idx][b] & m_raw[b];
                ne = d[b] & m_raw[b];
                if (ch && ne) exp_q.push_back(ev(1, idx, b));
                else if (ch && oe) exp_q.push_back(ev(0, idx, b));
            end
            m_mask[idx] = d;
        end
        @(negedge clk);
        reg_req = 1'b0;
        chk("R8 response strobe", 64'(reg_rsp), 64'(1));
        chk("R9 error flag", 64'(reg_err), 64'(m_err));
        rd = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input int idx, input logic [63:0] exp);
        logic [63:0] r;
        access(1'b0, idx, 2'd3, '0, '0, 1'b0, r);
        chk(req, r, exp);
    endtask

    task automatic wr_reg(input int idx, input logic [63:0] d);
        logic [63:0] r;
        access(1'b1, idx, 2'd3, d, '0, 1'b0, r);
        chk("R9 write returns zero", r, '0);
    endtask

    task automatic dev(input logic raise, input int n);
        @(negedge clk);
        dev_valid = 1'b1; dev_raise = raise; dev_line = 6'(n);
        @(posedge clk);
        if (raise) begin
            for (int c = 0; c < 4; c++) if (m_mask[c][n]) exp_q.push_back(ev(1, c, n));
            m_raw[n] = 1'b1;
        end else if (m_raw[n]) begin
            for (int c = 0; c < 4; c++) if (m_mask[c][n]) exp_q.push_back(ev(0, c, n));
            m_raw[n] = 1'b0;
        end
        @(negedge clk);
        dev_valid = 1'b0;
    endtask

    task automatic settle(input string req);
        int quiet = 0;
        for (int i = 0; i < 600 && quiet < 4; i++) begin
            @(negedge clk);
            quiet = evt_valid ? 0 : quiet + 1;
        end
        chk({req, " event count"}, 64'(got_q.size()), 64'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk({req, " event"}, 64'(got_q[i]), 64'(exp_q[i]));
        exp_q.delete();
        got_q.delete();
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] r;
        for (int c = 0; c < 4; c++) m_mask[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R1: reset state
        chk("R1 err after reset", 64'(reg_err), 64'(0));
        for (int i = 0; i < 9; i++) rd_chk("R1 reset read", i, '0);
        settle("R1");

        dev(1'b1, 5);                                // R5 unmasked raise
        settle("R5 no mask");
        rd_chk("R8 raw read", 8, 64'(1) << 5);

        wr_reg(0, (64'(1) << 5) | (64'(1) << 9));  // R3 post on mask write
        settle("R3");
        rd_chk("R2 eff0", 4, 64'(1) << 5);

        dev(1'b1, 9);                                // R5 masked raise
        settle("R5");

        wr_reg(1, '1);                               // R11 ascending order
        settle("R11 order");

        wr_reg(0, 64'(1) << 9);                      // R4 clear on unmask
        settle("R4 clear");

        wr_reg(2, 64'(1) << 40);                     // R4 raw clear: no event
        settle("R4 no event");
        rd_chk("R2 eff2", 6, '0);

        dev(1'b0, 9);                                // R6 real lower
        settle("R6");
        dev(1'b0, 9);                                // R7 spurious lower
        settle("R7");
        rd_chk("R7 raw unchanged", 8, 64'(1) << 5);

        wr_reg(3, (64'(1) << 63) | 64'(1));
        settle("R4 mask3");
        dev(1'b1, 63);                               // R11 across processors
        settle("R11 cross cpu");
        dev(1'b1, 0);
        settle("R5 line 0");
        rd_chk("R2 eff3", 7, (64'(1) << 63) | 64'(1));

        chk("R9 err still clear", 64'(reg_err), 64'(0));
        access(1'b1, 5, 2'd3, '1, '0, 1'b0, r);       // R9 write to effective
        rd_chk("R9 eff1 unchanged", 5, (64'(1) << 5) | (64'(1) << 63) | 64'(1));
        access(1'b1, 8, 2'd3, '0, '0, 1'b0, r);       // R9 write to raw
        rd_chk("R9 raw unchanged", 8, (64'(1) << 5) | (64'(1) << 63) | 64'(1));
        access(1'b0, 1, 2'd2, '0, '0, 1'b0, r);       // R9 bad size
        chk("R9 bad size rdata", r, '0);
        access(1'b0, 9, 2'd3, '0, '0, 1'b0, r);       // R9 out of range
        chk("R9 out of range rdata", r, '0);
        access(1'b0, 0, 2'd3, '0, BASE - 32'd64, 1'b1, r);
        chk("R9 below base rdata", r, '0);
        settle("R9");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule